// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM. Reads and writes can be issued in any mix on every clock, with no idle cycles between them. A command is captured on a rising edge. A write supplies its data two enabled edges later. A read presents its word from an output register two enabled edges after the command. The data path is 32 bits wide plus 4 parity bits, split into four byte lanes. Each lane carries its own active-low write select. Separate input, output and drive-enable signals take the place of a tristate bus.

A load cycle takes a new address. An advance cycle steps a 2-bit burst counter from the last loaded address, in either linear or interleaved order. A clock enable freezes the whole machine without deselecting it. The drive-enable output is gated by an asynchronous output enable. It is also held low whenever the slot that reached the output was not a read.

Top module: `pipe_sram`

## Requirements
- R1: A read command captured on an enabled edge puts the addressed word ({p_out, d_out}, parity in the top 4 bits) into the output register on the second enabled edge that follows, and dq_oe is high during the cycle after that edge when oe_n is low.
- R2: While clk_en_n is high, edges change nothing: no command, address, data or output is captured, no write commits, and the output word and dq_oe hold their values.
- R3: A load cycle (adv_ld low) issues a command only when sel1_n=0, sel2=1 and sel3_n=0. Any other combination issues an idle slot that neither reads nor writes.
- R4: A selected load cycle with wr_n low is a write. Its d_in/p_in are sampled on the second enabled edge after the command and stored at the command's address.
- R5: bmask_n is sampled with each command. A low bmask_n[i] writes d_in[8i+7:8i] and p_in[i]. Lanes whose select is high keep their stored value.
- R6: Reads and writes may alternate on consecutive enabled edges. A read returns the word as left by every write issued before it, including a write whose data arrives in the same cycle the read accesses the array (merged by byte mask). A write issued after a read does not affect that read.
- R7: dq_oe is low in every cycle after an enabled edge that delivered a write, an idle or a deselected slot, including the first read slot after a deselect has not yet reached the output.
- R8: oe_n acts without a clock: raising it forces dq_oe low at once, and lowering it lets a pending read drive again at once.
- R9: A cycle with adv_ld high repeats the operation of the last load and ignores the chip selects and wr_n. On the n-th advance since that load (n counted mod 4), the low two address bits are base^n when burst_ilv=1 and base+n mod 4 when burst_ilv=0. The upper bits stay the base address. An advance after a deselected load is idle.
- R10: While reset is asserted and after its release, dq_oe is low and the pipeline holds only idle slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| adv_ld | input | 1 | High: advance the burst; low: load a new address |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address for load cycles |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write command on load cycles, active low |
| bmask_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | 32 | Write data, sampled two enabled edges after the write |
| p_in | input | 4 | Write parity, one bit per lane |
| d_out | output | 32 | Registered read data |
| p_out | output | 4 | Registered read parity |
| dq_oe | output | 1 | High when the data outputs would be driven |

## Verification
A pipeline register that slips or misses an enable moves the dq_oe window by one cycle. It also puts a neighbouring command's word on d_out. Both show up within three edges of the affected read. A lost or misrouted write, a wrong lane mask or a missed bypass stays hidden until that address is read back, and then shows as a wrong byte or parity bit. A burst counter that steps wrongly shows on the first advanced beat as a word from the wrong address. A stall that leaks lets garbage data or a garbage command through, which later reads expose.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 8;
  localparam int DW      = LANES * LANE_W;
  localparam int WW      = DW + LANES;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // word layout: {parity[LANES-1:0], data[DW-1:0]}
  function automatic logic [WW-1:0] lane_merge(
    input logic [WW-1:0]    old_w,
    input logic [WW-1:0]    new_w,
    input logic [LANES-1:0] wen
  );
    logic [WW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++) begin
      if (wen[i]) begin
        r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        r[DW+i]               = new_w[DW+i];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/psram_rst_sync.sv
`timescale 1ns/1ps
module psram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/psram_burst.sv
`timescale 1ns/1ps
module psram_burst
  import psram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          en,
  input  logic          adv,
  input  logic          selected,
  input  logic          wr,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  output op_e           cmd_op,
  output logic [AW-1:0] cmd_addr
);
  op_e                op_q, op_d;
  logic [AW-1:0]      base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d, cnt_inc, lo;

  always_comb begin
    cnt_inc  = cnt_q + 1'b1;
    lo       = ilv ? (base_q[BURST_W-1:0] ^ cnt_inc) : (base_q[BURST_W-1:0] + cnt_inc);
    op_d     = op_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    if (adv) begin
      cnt_d    = cnt_inc;
      cmd_op   = op_q;
      cmd_addr = {base_q[AW-1:BURST_W], lo};
    end else begin
      op_d     = selected ? (wr ? OP_WR : OP_RD) : OP_IDLE;
      base_d   = addr;
      cnt_d    = '0;
      cmd_op   = op_d;
      cmd_addr = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      op_q   <= op_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R9: each enabled advance steps the counter by one and keeps the operation
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_q)
    en && adv |=> (cnt_q == $past(cnt_q) + 1'b1) && (op_q == $past(op_q)));
  // R9: a load restarts the burst at count zero
  a_r9_load_restart: assert property (@(posedge clk) disable iff (!rst_q)
    en && !adv |=> cnt_q == '0);
endmodule

// File: rtl/psram_array.sv
`timescale 1ns/1ps
module psram_array
  import psram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             en,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_wen,
  input  logic [WW-1:0]    wr_word,
  output logic [WW-1:0]    rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] rd_raw, rd_next;
  logic          hit;

  always_comb begin
    rd_raw  = mem[rd_addr];
    hit     = wr_en && (wr_addr == rd_addr);
    rd_next = hit ? lane_merge(rd_raw, wr_word, wr_wen) : rd_raw;
  end

  always_ff @(posedge clk) begin
    if (en && wr_en) mem[wr_addr] <= lane_merge(mem[wr_addr], wr_word, wr_wen);
  end

  always_ff @(posedge clk) begin
    if (en && rd_en) rd_word <= rd_next;
  end

  // R6: a read meeting a same-address write in flight takes the new lane
  a_r6_bypass_new: assert property (@(posedge clk) disable iff (!rst_q)
    en && rd_en && wr_en && (rd_addr == wr_addr) && wr_wen[0]
    |=> rd_word[LANE_W-1:0] == $past(wr_word[LANE_W-1:0]));
  // R5: a masked lane of that write leaves the stored byte in the read result
  a_r5_bypass_keep: assert property (@(posedge clk) disable iff (!rst_q)
    en && rd_en && wr_en && (rd_addr == wr_addr) && !wr_wen[0]
    |=> rd_word[LANE_W-1:0] == $past(rd_raw[LANE_W-1:0]));
endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
  import psram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int RST_SYNCS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              adv_ld,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  bmask_n,
  input  logic              oe_n,
  input  logic [DW-1:0]     d_in,
  input  logic [LANES-1:0]  p_in,
  output logic [DW-1:0]     d_out,
  output logic [LANES-1:0]  p_out,
  output logic              dq_oe
);
  logic rst_q, en, selected;
  assign en       = ~clk_en_n;
  assign selected = ~sel1_n & sel2 & ~sel3_n;

  psram_rst_sync #(.STAGES(RST_SYNCS)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  psram_burst #(.AW(ADDR_W)) u_burst (
    .clk(clk), .rst_q(rst_q), .en(en), .adv(adv_ld), .selected(selected),
    .wr(~wr_n), .ilv(burst_ilv), .addr(addr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  // two command stages: s1 = array access, s2 = write data / output
  op_e               s1_op_q, s1_op_d, s2_op_q, s2_op_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d;
  logic [LANES-1:0]  s1_wen_q, s1_wen_d, s2_wen_q, s2_wen_d;
  logic              out_vld_q, out_vld_d;
  logic [WW-1:0]     out_word_q, out_word_d;
  logic [WW-1:0]     rd_word;

  always_comb begin
    s1_op_d    = s1_op_q;
    s1_addr_d  = s1_addr_q;
    s1_wen_d   = s1_wen_q;
    s2_op_d    = s2_op_q;
    s2_addr_d  = s2_addr_q;
    s2_wen_d   = s2_wen_q;
    out_vld_d  = out_vld_q;
    out_word_d = out_word_q;
    if (en) begin
      s1_op_d   = cmd_op;
      s1_addr_d = cmd_addr;
      s1_wen_d  = ~bmask_n;
      s2_op_d   = s1_op_q;
      s2_addr_d = s1_addr_q;
      s2_wen_d  = s1_wen_q;
      out_vld_d = (s2_op_q == OP_RD);
      if (s2_op_q == OP_RD) out_word_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_op_q    <= OP_IDLE;
      s1_addr_q  <= '0;
      s1_wen_q   <= '0;
      s2_op_q    <= OP_IDLE;
      s2_addr_q  <= '0;
      s2_wen_q   <= '0;
      out_vld_q  <= 1'b0;
      out_word_q <= '0;
    end else begin
      s1_op_q    <= s1_op_d;
      s1_addr_q  <= s1_addr_d;
      s1_wen_q   <= s1_wen_d;
      s2_op_q    <= s2_op_d;
      s2_addr_q  <= s2_addr_d;
      s2_wen_q   <= s2_wen_d;
      out_vld_q  <= out_vld_d;
      out_word_q <= out_word_d;
    end
  end

  psram_array #(.AW(ADDR_W)) u_array (
    .clk(clk), .rst_q(rst_q), .en(en),
    .rd_en(s1_op_q == OP_RD), .rd_addr(s1_addr_q),
    .wr_en(s2_op_q == OP_WR), .wr_addr(s2_addr_q), .wr_wen(s2_wen_q),
    .wr_word({p_in, d_in}),
    .rd_word(rd_word)
  );

  assign d_out = out_word_q[DW-1:0];
  assign p_out = out_word_q[WW-1:DW];
  assign dq_oe = out_vld_q & ~oe_n;

  // R2: a masked clock edge changes no pipeline or output state
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_q)
    clk_en_n |=> $stable(s1_op_q) && $stable(s2_op_q) && $stable(out_vld_q)
                 && $stable(out_word_q));
  // R3: a load with the chip not selected enters an idle slot
  a_r3_deselect_idle: assert property (@(posedge clk) disable iff (!rst_q)
    en && !adv_ld && !(~sel1_n && sel2 && ~sel3_n) |=> s1_op_q == OP_IDLE);
  // R1: a read reaching the last stage is presented on the next edge
  a_r1_read_present: assert property (@(posedge clk) disable iff (!rst_q)
    en && (s2_op_q == OP_RD) |=> out_vld_q);
  // R7: any other slot leaves the outputs undriven
  a_r7_no_drive: assert property (@(posedge clk) disable iff (!rst_q)
    en && (s2_op_q != OP_RD) |=> !dq_oe);
  // R10: nothing drives while the synchronised reset is low
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_q |-> !out_vld_q);
endmodule

// File: tb/pipe_sram_tb.sv
`timescale 1ns/1ps
module pipe_sram_tb;
  localparam int AW = 6;

  logic clk, rst_n, clk_en_n, adv_ld, burst_ilv, sel1_n, sel2, sel3_n, wr_n, oe_n;
  logic [AW-1:0] addr;
  logic [3:0]    bmask_n, p_in, p_out;
  logic [31:0]   d_in, d_out;
  logic          dq_oe;

  pipe_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
    .burst_ilv(burst_ilv), .addr(addr), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .wr_n(wr_n), .bmask_n(bmask_n), .oe_n(oe_n),
    .d_in(d_in), .p_in(p_in), .d_out(d_out), .p_out(p_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state (0 idle, 1 read, 2 write)
  logic [35:0]   ref_mem [64];
  logic [1:0]    m_s1_op, m_s2_op, b_op, b_cnt;
  logic [AW-1:0] m_s1_a, m_s2_a, b_base;
  logic [3:0]    m_s1_m, m_s2_m;
  logic [35:0]   m_s1_d, m_s2_d, m_out;
  logic          m_vld;

  function automatic logic [35:0] pat(int s);
    return {4'(s * 7 + 3), (32'(s) * 32'h9E3779B1) ^ 32'h5A5A0F0F};
  endfunction

  task automatic chk(string rq, string what, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic cyc(string rq, logic ce_n, logic adv, logic [2:0] cs, logic wrn,
                     logic [3:0] bm, logic [AW-1:0] a, logic [35:0] wd, logic oen);
    logic [1:0]    nop, ninc, lo;
    logic [AW-1:0] na;
    clk_en_n = ce_n; adv_ld = adv; {sel1_n, sel2, sel3_n} = cs;
    wr_n = wrn; bmask_n = bm; addr = a; oe_n = oen;
    {p_in, d_in} = ce_n ? ~m_s2_d : m_s2_d;
    @(posedge clk);
    if (!ce_n) begin
      if (m_s2_op == 2'd1) m_out = ref_mem[m_s2_a];
      m_vld = (m_s2_op == 2'd1);
      if (m_s2_op == 2'd2)
        for (int i = 0; i < 4; i++)
          if (m_s2_m[i]) begin
            ref_mem[m_s2_a][i*8 +: 8] = m_s2_d[i*8 +: 8];
            ref_mem[m_s2_a][32+i]     = m_s2_d[32+i];
          end
      if (adv) begin
        ninc = b_cnt + 2'd1;
        lo   = burst_ilv ? (b_base[1:0] ^ ninc) : (b_base[1:0] + ninc);
        nop  = b_op;
        na   = {b_base[AW-1:2], lo};
        b_cnt = ninc;
      end else begin
        nop    = (cs == 3'b010) ? (wrn ? 2'd1 : 2'd2) : 2'd0;
        na     = a;
        b_op   = nop;
        b_base = a;
        b_cnt  = 2'd0;
      end
      m_s2_op = m_s1_op; m_s2_a = m_s1_a; m_s2_m = m_s1_m; m_s2_d = m_s1_d;
      m_s1_op = nop;     m_s1_a = na;     m_s1_m = ~bm;    m_s1_d = wd;
    end
    @(negedge clk);
    chk(rq, "drive", {35'b0, dq_oe}, {35'b0, m_vld & ~oen});
    if (m_vld) chk(rq, "word", {p_out, d_out}, m_out);
  endtask

  task automatic op_wr(string rq, logic [AW-1:0] a, logic [3:0] bm, logic [35:0] wd);
    cyc(rq, 1'b0, 1'b0, 3'b010, 1'b0, bm, a, wd, 1'b0);
  endtask
  task automatic op_rd(string rq, logic [AW-1:0] a);
    cyc(rq, 1'b0, 1'b0, 3'b010, 1'b1, 4'hF, a, 36'h0, 1'b0);
  endtask
  task automatic op_nop(string rq);
    cyc(rq, 1'b0, 1'b0, 3'b101, 1'b1, 4'hF, '0, 36'h0, 1'b0);
  endtask
  task automatic op_stall(string rq);
    cyc(rq, 1'b1, 1'b0, 3'b010, 1'b0, 4'h0, 6'd51, pat(9), 1'b0);
  endtask

  task automatic oe_probe(string rq);
    chk(rq, "probe setup", {35'b0, m_vld}, 36'd1);
    oe_n = 1'b1; #1;
    chk(rq, "async oe high", {35'b0, dq_oe}, 36'd0);
    oe_n = 1'b0; #1;
    chk(rq, "async oe low", {35'b0, dq_oe}, 36'd1);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_s1_op = 0; m_s2_op = 0; b_op = 0; b_cnt = 0; b_base = '0;
    m_s1_a = '0; m_s2_a = '0; m_s1_m = 0; m_s2_m = 0; m_s1_d = 0; m_s2_d = 0;
    m_out = 0; m_vld = 0;
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    rst_n = 1'b0; clk_en_n = 1'b0; adv_ld = 1'b0; burst_ilv = 1'b1;
    {sel1_n, sel2, sel3_n} = 3'b101; wr_n = 1'b1; bmask_n = 4'hF;
    addr = '0; oe_n = 1'b0; d_in = '0; p_in = '0;
    repeat (3) @(negedge clk);
    chk("R10", "drive in reset", {35'b0, dq_oe}, 36'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "drive after reset", {35'b0, dq_oe}, 36'd0);

    // R4: fill every word, then R1: read them all back
    for (int a = 0; a < 64; a++) op_wr("R4", 6'(a), 4'h0, pat(a));
    op_nop("R4"); op_nop("R4");
    for (int a = 0; a < 64; a++) op_rd("R1", 6'(a));
    op_nop("R1"); op_nop("R1");

    // R5: every lane mask
    for (int m = 0; m < 16; m++) begin
      op_wr("R5", 6'(m), 4'(m), pat(100 + m));
      op_nop("R5"); op_nop("R5");
      op_rd("R5", 6'(m));
      op_nop("R5"); op_nop("R5");
    end

    // R6: write then read same address on the next edge, and read before write
    for (int i = 0; i < 16; i++) begin
      op_wr("R6", 6'(20 + i), 4'(i), pat(200 + i));
      op_rd("R6", 6'(20 + i));
    end
    for (int i = 0; i < 8; i++) begin
      op_rd("R6", 6'(40 + i));
      op_wr("R6", 6'(40 + i), 4'h0, pat(300 + i));
      op_rd("R6", 6'(40 + i));
    end
    op_nop("R6"); op_nop("R6");

    // R2: stalls with live garbage on every input
    op_wr("R2", 6'd50, 4'h0, pat(400));
    op_stall("R2"); op_stall("R2"); op_stall("R2");
    op_rd("R2", 6'd50);
    op_stall("R2"); op_nop("R2"); op_stall("R2"); op_stall("R2");
    op_nop("R2"); op_stall("R2"); op_nop("R2");
    op_rd("R2", 6'd51); op_nop("R2"); op_nop("R2");

    // R3: all chip-select combinations for writes and reads
    for (int c = 0; c < 8; c++) begin
      cyc("R3", 1'b0, 1'b0, 3'(c), 1'b0, 4'h0, 6'd60, pat(500 + c), 1'b0);
      op_nop("R3"); op_nop("R3");
      op_rd("R3", 6'd60);
      op_nop("R3"); op_nop("R3");
      cyc("R3", 1'b0, 1'b0, 3'(c), 1'b1, 4'hF, 6'd61, 36'h0, 1'b0);
      op_nop("R3"); op_nop("R3");
    end

    // R7: output enable high, and write slots, never drive
    op_rd("R7", 6'd1);
    cyc("R7", 1'b0, 1'b0, 3'b101, 1'b1, 4'hF, '0, 36'h0, 1'b1);
    cyc("R7", 1'b0, 1'b0, 3'b101, 1'b1, 4'hF, '0, 36'h0, 1'b1);
    op_wr("R7", 6'd2, 4'h0, pat(700)); op_nop("R7"); op_nop("R7");
    op_nop("R7"); op_rd("R7", 6'd2); op_nop("R7"); op_nop("R7");

    // R8: asynchronous output enable
    op_rd("R8", 6'd3); op_nop("R8"); op_nop("R8");
    oe_probe("R8");
    op_nop("R8");

    // R9: bursts in both orders from every start offset
    for (int md = 0; md < 2; md++) begin
      for (int lo = 0; lo < 4; lo++) begin
        burst_ilv = md[0];
        op_wr("R9", 6'(32 + lo), 4'h0, pat(600 + md * 16 + lo * 4));
        for (int k = 1; k < 4; k++)
          cyc("R9", 1'b0, 1'b1, 3'b101, 1'b1, 4'(k * 5), '0,
              pat(600 + md * 16 + lo * 4 + k), 1'b0);
        op_nop("R9"); op_nop("R9");
        op_rd("R9", 6'(32 + ((lo + 1) % 4)));
        for (int k = 1; k < 4; k++)
          cyc("R9", 1'b0, 1'b1, 3'b101, 1'b0, 4'h0, '0, 36'h0, 1'b0);
        op_nop("R9"); op_nop("R9");
      end
    end
    op_nop("R9");
    cyc("R9", 1'b0, 1'b1, 3'b010, 1'b1, 4'hF, '0, 36'h0, 1'b0);
    cyc("R9", 1'b0, 1'b1, 3'b010, 1'b0, 4'h0, '0, pat(800), 1'b0);
    op_nop("R9"); op_nop("R9");
    op_rd("R9", 6'd33);
    for (int k = 0; k < 5; k++)
      cyc("R9", 1'b0, 1'b1, 3'b101, 1'b1, 4'hF, '0, 36'h0, 1'b0);
    op_nop("R9"); op_nop("R9");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule